// File: doc/BRIEF.md
# Parallel Bus Initiator Handshake Responder

This block is the initiator-side partner of an interlocked, asynchronous request/acknowledge transfer on a parallel peripheral bus. The target drives a request line together with three phase lines (message, control/data and direction). The block answers every request with an acknowledge. The answer follows a four-step interlock: the request rises, then the acknowledge rises, then the request falls, then the acknowledge falls. When the direction line points toward the initiator, the block takes the bus data and hands it to local logic. When it points the other way, the block takes a word from local logic, drives it onto the bus with parity and waits a programmable settle time before it acknowledges.

All target-driven control lines pass through two-flop synchronizers. The phase code is sampled only on the synchronized rising edge of the request, so the phase lines may wander freely between transfers. Software supplies an expected phase. If the sampled phase differs from it, the block raises a mismatch flag and holds back the acknowledge until local logic clears the flag. The bus works as one byte lane (narrow) or as two byte lanes (wide). Each lane carries an odd parity bit. Received parity is checked per enabled lane, and any error is held in a sticky status bit.

Top module: `pbus_init_resp`

## Requirements
- R1: After reset, bus_ack_o, bus_data_oe_o, rx_valid_o, phase_mismatch_o, parity_err_o and phase_valid_o are all 0.
- R2: phase_o is coded {MSG, C/D, I/O} in bits [2:0]. It is loaded only on a synchronized rising edge of the request, and after that edge phase_valid_o is 1. Changes on the phase lines while the request is low do not alter phase_o and do not raise bus_ack_o.
- R3: When the sampled I/O bit is 1 (target to initiator), the bus data present at the request edge appears on rx_data_o with rx_valid_o set. bus_ack_o stays 0 until local logic accepts the word (rx_valid_o and rx_ready_i both 1).
- R4: bus_ack_o rises only while the synchronized request is high. It falls only after the synchronized request has been seen low.
- R5: In narrow mode (wide_en=0), only bits [7:0] and parity bit 0 are used. rx_data_o[15:8] reads 0, and a bad parity bit on the upper lane does not set parity_err_o.
- R6: In wide mode (wide_en=1), all 16 data bits are transferred in both directions, and both parity bits are checked or generated.
- R7: If the sampled phase differs from exp_phase, phase_mismatch_o is set and bus_ack_o stays 0. A one-cycle pulse on mismatch_clr_i clears the flag, and the transfer then completes in the direction given by the sampled I/O bit.
- R8: When the sampled I/O bit is 0 (initiator to target), a word is accepted when tx_valid_i and tx_ready_o are both 1. bus_data_oe_o then rises, and bus_ack_o rises settle_cycles+1 clock cycles after the acceptance edge. bus_data_o stays constant while bus_data_oe_o is 1.
- R9: For each enabled lane, the received data byte and its parity bit must hold an odd number of ones. A violation sets parity_err_o, which stays 1 until reset.
- R10: Outgoing parity bits give each enabled lane an odd count of ones. In narrow mode, bus_data_o[15:8] and bus_par_o[1] are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wide_en | input | 1 | 1 selects two byte lanes, 0 selects one |
| settle_cycles | input | 4 | Extra cycles between driving outgoing data and acknowledging |
| exp_phase | input | 3 | Expected phase code {MSG, C/D, I/O} |
| bus_req_i | input | 1 | Request from the target (asynchronous) |
| bus_cd_i | input | 1 | Control/data phase line from the target |
| bus_io_i | input | 1 | Direction phase line, 1 = target to initiator |
| bus_msg_i | input | 1 | Message phase line from the target |
| bus_data_i | input | 16 | Bus data from the target |
| bus_par_i | input | 2 | Odd parity per lane from the target |
| bus_ack_o | output | 1 | Acknowledge to the target |
| bus_data_o | output | 16 | Outgoing bus data |
| bus_par_o | output | 2 | Outgoing odd parity per lane |
| bus_data_oe_o | output | 1 | Enable for the outgoing data drivers |
| rx_valid_o | output | 1 | Received word available |
| rx_ready_i | input | 1 | Local logic accepts the received word |
| rx_data_o | output | 16 | Received word |
| tx_valid_i | input | 1 | Local logic offers a word to send |
| tx_ready_o | output | 1 | Block accepts the offered word |
| tx_data_i | input | 16 | Word to send |
| phase_o | output | 3 | Last sampled phase {MSG, C/D, I/O} |
| phase_valid_o | output | 1 | A phase has been sampled since reset |
| phase_mismatch_o | output | 1 | Sampled phase differs from exp_phase |
| mismatch_clr_i | input | 1 | Local acknowledge of a phase mismatch |
| parity_err_o | output | 1 | Sticky received-parity error |

## Verification
The assertions assume the target keeps the request high until it sees the acknowledge. They also assume the target holds the phase lines and incoming data steady from shortly before the request rises until the acknowledge, and that it does not raise the request again before the acknowledge has fallen. The bench's target tasks follow this rule. They set the phase and data several cycles ahead of the request, wait for each acknowledge edge before they move the request, and wander the phase lines only while the request and acknowledge are both low. The settle-delay measurement counts cycles from the local acceptance edge, so it depends on the local side offering data only while tx_ready_o is high.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef struct packed {
    logic msg;
    logic cd;
    logic io;
  } phase_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MISM,
    ST_RX,
    ST_TXW,
    ST_SET,
    ST_ACK
  } hs_state_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q;
    logic stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= d[i];
        stab_q <= meta_q;
      end
    end
    assign q[i] = stab_q;
  end
endmodule

// File: rtl/hs_lane_parity.sv
module hs_lane_parity #(
  parameter int LANES = 2,
  parameter int LW    = 8
) (
  input  logic [LANES*LW-1:0] data,
  output logic [LANES-1:0]    odd_bit
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign odd_bit[i] = ~^data[i*LW +: LW];
  end
endmodule

// File: rtl/hs_ctrl.sv
module hs_ctrl
  import hs_pkg::*;
#(
  parameter int SETTLE_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_s,
  input  phase_t              phase_s,
  input  phase_t              exp_phase,
  input  logic                mism_clr,
  input  logic                rx_ready,
  input  logic                tx_valid,
  input  logic [SETTLE_W-1:0] settle,
  output logic                ack,
  output logic                rx_valid,
  output logic                tx_ready,
  output logic                tx_load,
  output logic                cap,
  output logic                oe,
  output phase_t              phase_q,
  output logic                phase_valid,
  output logic                mism
);
  hs_state_e           state_q, state_n;
  logic [SETTLE_W-1:0] cnt_q, cnt_n;
  phase_t              phase_n;
  logic                pv_q, pv_n;
  logic                oe_q, oe_n;
  logic                ack_q, ack_n;
  logic                req_d;
  logic                req_rise;

  assign req_rise = req_s & ~req_d;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    phase_n = phase_q;
    pv_n    = pv_q;
    oe_n    = oe_q;
    case (state_q)
      ST_IDLE: begin
        if (req_rise) begin
          phase_n = phase_s;
          pv_n    = 1'b1;
          if (phase_s != exp_phase) state_n = ST_MISM;
          else if (phase_s.io)      state_n = ST_RX;
          else                      state_n = ST_TXW;
        end
      end
      ST_MISM: begin
        if (mism_clr) state_n = phase_q.io ? ST_RX : ST_TXW;
      end
      ST_RX: begin
        if (rx_ready) state_n = ST_ACK;
      end
      ST_TXW: begin
        if (tx_valid) begin
          state_n = ST_SET;
          cnt_n   = settle;
          oe_n    = 1'b1;
        end
      end
      ST_SET: begin
        if (cnt_q == '0) state_n = ST_ACK;
        else             cnt_n   = cnt_q - 1'b1;
      end
      ST_ACK: begin
        if (!req_s) begin
          state_n = ST_IDLE;
          oe_n    = 1'b0;
        end
      end
      default: state_n = ST_IDLE;
    endcase
    ack_n = (state_n == ST_ACK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      phase_q <= '0;
      pv_q    <= 1'b0;
      oe_q    <= 1'b0;
      ack_q   <= 1'b0;
      req_d   <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      phase_q <= phase_n;
      pv_q    <= pv_n;
      oe_q    <= oe_n;
      ack_q   <= ack_n;
      req_d   <= req_s;
    end
  end

  assign ack         = ack_q;
  assign oe          = oe_q;
  assign phase_valid = pv_q;
  assign rx_valid    = (state_q == ST_RX);
  assign tx_ready    = (state_q == ST_TXW);
  assign tx_load     = (state_q == ST_TXW) & tx_valid;
  assign cap         = (state_q == ST_IDLE) & req_rise & phase_s.io;
  assign mism        = (state_q == ST_MISM);

  assert_phase_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_rise |=> $stable(phase_q));
  assert_rx_ack_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ack) && phase_q.io) |-> $past(rx_valid && rx_ready));
  assert_ack_rise_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> req_s);
  assert_ack_fall_after_req_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack) |-> !$past(req_s));
  assert_mism_clear_by_local_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mism) |-> $past(mism_clr));
endmodule

// File: rtl/pbus_init_resp.sv
module pbus_init_resp
  import hs_pkg::*;
#(
  parameter int LANES    = 2,
  parameter int LW       = 8,
  parameter int SETTLE_W = 4,
  localparam int DW      = LANES * LW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wide_en,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic [2:0]          exp_phase,
  input  logic                bus_req_i,
  input  logic                bus_cd_i,
  input  logic                bus_io_i,
  input  logic                bus_msg_i,
  input  logic [DW-1:0]       bus_data_i,
  input  logic [LANES-1:0]    bus_par_i,
  output logic                bus_ack_o,
  output logic [DW-1:0]       bus_data_o,
  output logic [LANES-1:0]    bus_par_o,
  output logic                bus_data_oe_o,
  output logic                rx_valid_o,
  input  logic                rx_ready_i,
  output logic [DW-1:0]       rx_data_o,
  input  logic                tx_valid_i,
  output logic                tx_ready_o,
  input  logic [DW-1:0]       tx_data_i,
  output logic [2:0]          phase_o,
  output logic                phase_valid_o,
  output logic                phase_mismatch_o,
  input  logic                mismatch_clr_i,
  output logic                parity_err_o
);
  logic           rst_m, rst_int;
  logic [3:0]     sync_q;
  phase_t         phase_s, phase_q;
  logic           cap, tx_load, oe;
  logic [LANES-1:0] lane_en, rx_gen, tx_gen;
  logic [DW-1:0]  lane_mask;
  logic [DW-1:0]  rx_q, rx_n, tx_q, tx_n;
  logic           perr_q, perr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m   <= 1'b0;
      rst_int <= 1'b0;
    end else begin
      rst_m   <= 1'b1;
      rst_int <= rst_m;
    end
  end

  hs_sync #(.W(4)) u_sync (
    .clk   (clk),
    .rst_n (rst_int),
    .d     ({bus_req_i, bus_msg_i, bus_cd_i, bus_io_i}),
    .q     (sync_q)
  );
  assign phase_s = phase_t'(sync_q[2:0]);

  for (genvar i = 0; i < LANES; i++) begin : g_mask
    if (i == 0) begin : g_base
      assign lane_en[i] = 1'b1;
    end else begin : g_upper
      assign lane_en[i] = wide_en;
    end
    assign lane_mask[i*LW +: LW] = {LW{lane_en[i]}};
  end

  hs_ctrl #(.SETTLE_W(SETTLE_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int),
    .req_s       (sync_q[3]),
    .phase_s     (phase_s),
    .exp_phase   (phase_t'(exp_phase)),
    .mism_clr    (mismatch_clr_i),
    .rx_ready    (rx_ready_i),
    .tx_valid    (tx_valid_i),
    .settle      (settle_cycles),
    .ack         (bus_ack_o),
    .rx_valid    (rx_valid_o),
    .tx_ready    (tx_ready_o),
    .tx_load     (tx_load),
    .cap         (cap),
    .oe          (oe),
    .phase_q     (phase_q),
    .phase_valid (phase_valid_o),
    .mism        (phase_mismatch_o)
  );

  hs_lane_parity #(.LANES(LANES), .LW(LW)) u_rx_par (
    .data    (bus_data_i),
    .odd_bit (rx_gen)
  );
  hs_lane_parity #(.LANES(LANES), .LW(LW)) u_tx_par (
    .data    (tx_q),
    .odd_bit (tx_gen)
  );

  always_comb begin
    rx_n   = rx_q;
    tx_n   = tx_q;
    perr_n = perr_q;
    if (cap) begin
      rx_n = bus_data_i & lane_mask;
      if (|(lane_en & (bus_par_i ^ rx_gen))) perr_n = 1'b1;
    end
    if (tx_load) tx_n = tx_data_i & lane_mask;
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      rx_q   <= '0;
      tx_q   <= '0;
      perr_q <= 1'b0;
    end else begin
      rx_q   <= rx_n;
      tx_q   <= tx_n;
      perr_q <= perr_n;
    end
  end

  assign rx_data_o     = rx_q;
  assign bus_data_o    = tx_q;
  assign bus_par_o     = tx_gen & lane_en;
  assign bus_data_oe_o = oe;
  assign phase_o       = phase_q;
  assign parity_err_o  = perr_q;

  assert_tx_data_stable_R8: assert property (@(posedge clk) disable iff (!rst_int)
    (oe && $past(oe)) |-> $stable(bus_data_o));
  assert_parity_sticky_R9: assert property (@(posedge clk) disable iff (!rst_int)
    parity_err_o |=> parity_err_o);
  assert_narrow_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_int)
    (!wide_en && $past(!wide_en) && $rose(oe)) |-> (bus_data_o[DW-1:LW] == '0));
endmodule

// File: tb/test_pbus_init_resp.sv
module test_pbus_init_resp;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, wide_en;
  logic [3:0]  settle_cycles;
  logic [2:0]  exp_phase, tgt_phase;
  logic        bus_req_i;
  logic [15:0] bus_data_i, bus_data_o, rx_data_o, tx_data_i;
  logic [1:0]  bus_par_i, bus_par_o;
  logic        bus_ack_o, bus_data_oe_o, rx_valid_o, rx_ready_i, tx_valid_i, tx_ready_o;
  logic [2:0]  phase_o;
  logic        phase_valid_o, phase_mismatch_o, mismatch_clr_i, parity_err_o;

  int checks = 0;
  int fails  = 0;
  logic [15:0] rx_exp_q[$];
  logic [17:0] tx_exp_q[$];

  pbus_init_resp i_pbus_init_resp (
    .clk(clk), .rst_n(rst_n), .wide_en(wide_en), .settle_cycles(settle_cycles),
    .exp_phase(exp_phase), .bus_req_i(bus_req_i), .bus_cd_i(tgt_phase[1]),
    .bus_io_i(tgt_phase[0]), .bus_msg_i(tgt_phase[2]), .bus_data_i(bus_data_i),
    .bus_par_i(bus_par_i), .bus_ack_o(bus_ack_o), .bus_data_o(bus_data_o),
    .bus_par_o(bus_par_o), .bus_data_oe_o(bus_data_oe_o), .rx_valid_o(rx_valid_o),
    .rx_ready_i(rx_ready_i), .rx_data_o(rx_data_o), .tx_valid_i(tx_valid_i),
    .tx_ready_o(tx_ready_o), .tx_data_i(tx_data_i), .phase_o(phase_o),
    .phase_valid_o(phase_valid_o), .phase_mismatch_o(phase_mismatch_o),
    .mismatch_clr_i(mismatch_clr_i), .parity_err_o(parity_err_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] odd_par(input logic [15:0] d);
    return {~^d[15:8], ~^d[7:0]};
  endfunction

  // monitor: received words against the scoreboard
  always @(negedge clk) begin
    if (rst_n && rx_valid_o && rx_ready_i) begin
      if (rx_exp_q.size() == 0) check("R3 unexpected rx word", {16'h0, rx_data_o}, 32'hffff_ffff);
      else                      check("R3 rx word", {16'h0, rx_data_o}, {16'h0, rx_exp_q.pop_front()});
    end
  end

  task automatic wait_ack(input logic v);
    int n = 0;
    while (bus_ack_o !== v && n < 300) begin
      @(negedge clk);
      n++;
    end
    if (bus_ack_o !== v) check("R4 ack handshake timeout", {31'h0, bus_ack_o}, {31'h0, v});
  endtask

  task automatic target_in(input logic [2:0] ph, input logic [15:0] d, input logic [1:0] p);
    tgt_phase  = ph;
    bus_data_i = d;
    bus_par_i  = p;
    repeat (3) @(negedge clk);
    bus_req_i = 1'b1;
    wait_ack(1'b1);
    @(negedge clk);
    bus_req_i = 1'b0;
    wait_ack(1'b0);
    @(negedge clk);
  endtask

  task automatic target_out(input logic [2:0] ph);
    logic [17:0] e;
    tgt_phase = ph;
    repeat (3) @(negedge clk);
    bus_req_i = 1'b1;
    wait_ack(1'b1);
    check("R8 oe during ack", {31'h0, bus_data_oe_o}, 32'h1);
    e = (tx_exp_q.size() != 0) ? tx_exp_q.pop_front() : 18'h3ffff;
    check("R8 R10 tx word+parity", {14'h0, bus_par_o, bus_data_o}, {14'h0, e});
    @(negedge clk);
    bus_req_i = 1'b0;
    wait_ack(1'b0);
    @(negedge clk);
    check("R8 oe released", {31'h0, bus_data_oe_o}, 32'h0);
  endtask

  task automatic local_send(input logic [15:0] d, input logic [3:0] s);
    int n = 0;
    logic [15:0] m;
    m = wide_en ? d : {8'h00, d[7:0]};
    tx_exp_q.push_back({odd_par(m) & {wide_en, 1'b1}, m});
    settle_cycles = s;
    tx_data_i  = d;
    tx_valid_i = 1'b1;
    while (!tx_ready_o && n < 300) begin @(negedge clk); n++; end
    @(posedge clk);
    n = 0;
    do begin
      @(negedge clk);
      if (n == 0) tx_valid_i = 1'b0;
      n++;
    end while (!bus_ack_o && n < 100);
    check("R8 settle delay to ack", n, s + 2);
  endtask

  task automatic rx_word(input logic [15:0] d, input logic [1:0] p, input logic [15:0] e);
    rx_exp_q.push_back(e);
    target_in(3'b001, d, p);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wide_en = 1'b0; settle_cycles = '0; exp_phase = 3'b001;
    tgt_phase = 3'b000; bus_req_i = 1'b0; bus_data_i = '0; bus_par_i = '0;
    rx_ready_i = 1'b1; tx_valid_i = 1'b0; tx_data_i = '0; mismatch_clr_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 ack", {31'h0, bus_ack_o}, 0);
    check("R1 oe", {31'h0, bus_data_oe_o}, 0);
    check("R1 rx_valid", {31'h0, rx_valid_o}, 0);
    check("R1 mismatch", {31'h0, phase_mismatch_o}, 0);
    check("R1 parity err", {31'h0, parity_err_o}, 0);
    check("R1 phase valid", {31'h0, phase_valid_o}, 0);

    // R5 narrow receive: upper lane junk with bad parity ignored
    rx_word(16'hA55A, {~odd_par(16'hA55A)[1], odd_par(16'hA55A)[0]}, 16'h005A);
    check("R2 phase sampled", {29'h0, phase_o}, 32'h1);
    check("R2 phase valid", {31'h0, phase_valid_o}, 1);
    check("R5 no upper-lane error in narrow", {31'h0, parity_err_o}, 0);
    rx_word(16'h0000, odd_par(16'h0000), 16'h0000);
    rx_word(16'h12FF, odd_par(16'h12FF), 16'h00FF);
    rx_word(16'h0081, odd_par(16'h0081), 16'h0081);

    // R3 ack withheld until local accept
    rx_ready_i = 1'b0;
    rx_exp_q.push_back(16'h003C);
    fork
      target_in(3'b001, 16'h003C, odd_par(16'h003C));
      begin
        while (!rx_valid_o) @(negedge clk);
        repeat (8) begin
          @(negedge clk);
          check("R3 no ack before accept", {31'h0, bus_ack_o}, 0);
        end
        rx_ready_i = 1'b1;
      end
    join

    // R2 wandering phase lines ignored while request low
    tgt_phase = 3'b110; repeat (3) @(negedge clk);
    tgt_phase = 3'b010; repeat (3) @(negedge clk);
    tgt_phase = 3'b111; repeat (3) @(negedge clk);
    tgt_phase = 3'b000; repeat (3) @(negedge clk);
    check("R2 phase held while req low", {29'h0, phase_o}, 32'h1);
    check("R2 no ack from phase lines", {31'h0, bus_ack_o}, 0);

    // R8 / R10 narrow send with two settle values
    exp_phase = 3'b000;
    fork local_send(16'h1234, 4'd0); target_out(3'b000); join
    check("R2 phase now data-out", {29'h0, phase_o}, 32'h0);
    fork local_send(16'hBE77, 4'd5); target_out(3'b000); join

    // R6 wide receive and send
    wide_en = 1'b1;
    exp_phase = 3'b001;
    rx_word(16'hBEEF, odd_par(16'hBEEF), 16'hBEEF);
    check("R6 wide rx no parity error", {31'h0, parity_err_o}, 0);
    exp_phase = 3'b000;
    fork local_send(16'hC3A5, 4'd2); target_out(3'b000); join

    // R7 phase mismatch holds ack until local clear
    exp_phase = 3'b001;
    rx_exp_q.push_back(16'h1357);
    fork
      target_in(3'b011, 16'h1357, odd_par(16'h1357));
      begin
        while (!phase_mismatch_o) @(negedge clk);
        check("R7 mismatched phase latched", {29'h0, phase_o}, 32'h3);
        repeat (10) begin
          @(negedge clk);
          check("R7 no ack during mismatch", {31'h0, bus_ack_o}, 0);
        end
        mismatch_clr_i = 1'b1;
        @(negedge clk);
        mismatch_clr_i = 1'b0;
      end
    join
    check("R7 mismatch cleared", {31'h0, phase_mismatch_o}, 0);

    // R9 bad parity on the upper lane in wide mode is sticky
    rx_word(16'h0F0F, {~odd_par(16'h0F0F)[1], odd_par(16'h0F0F)[0]}, 16'h0F0F);
    check("R9 parity error set", {31'h0, parity_err_o}, 1);
    rx_word(16'h4242, odd_par(16'h4242), 16'h4242);
    check("R9 parity error sticky", {31'h0, parity_err_o}, 1);

    repeat (5) @(negedge clk);
    check("R3 scoreboard drained", rx_exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule